// File: doc/BRIEF.md
# Multi-Chain Mux-D Scan Wrapper

This block places a bank of scan cells around a small piece of combinational logic under test. A functional input vector feeds the logic, and each logic output bit lands in one cell. Each cell holds two edge-triggered D flip-flops. The output flop drives the functional output seen by downstream logic. The shadow flop takes part in the scan chain. The cells are grouped into several balanced chains, and each chain has its own serial input and output. A chain of length L can be fully loaded or unloaded in L shifts, so the whole bank takes as many shifts as its longest chain.

Three synchronous controls select what each clock edge does: a test-mode input, a scan-enable and a capture strobe.
- **Operate:** with test mode low, the output flops follow the logic every cycle.
- **Sample:** the shadow flops record the logic response.
- **Shift:** the shadow flops move one position along every chain. The old contents leave on the serial outputs while new contents enter.
- **Apply:** the shadow contents are copied onto the functional output, so a shifted-in state drives downstream logic.

A synchronous reset clears every flop. All flops are clocked directly from the single clock input.

Top module: `scan_wrap`

## Requirements
- R1: While `rst` is high at a rising edge, every output flop and every shadow flop is cleared to 0, whatever the other inputs are, so `funcOut` and `scanOut` read 0 after that edge.
- R2: When `testMode` is 0, `funcOut` after each rising edge equals the logic response to the `funcIn` sampled at that edge, whatever `scanEn` and `captureStrobe` are.
- R3: When `scanEn` is 0 and `captureStrobe` is 1 at a rising edge, every shadow flop loads the logic response bit for its own cell.
- R4: When `scanEn` is 1 at a rising edge, every chain moves one position. Chain k occupies the contiguous cell indices start(k) to start(k)+len(k)-1. `scanIn[k]` enters cell start(k). Each cell passes its value to the next higher index. `scanOut[k]` always shows the shadow flop of the highest cell of chain k.
- R5: With N = `NUM_FLOPS` and C = `NUM_CHAINS`, chain k has length floor(N/C), plus 1 when k < N mod C. Chains are laid out in ascending k from cell 0.
- R6: When `testMode` is 1 and both `scanEn` and `captureStrobe` are 0 at a rising edge, `funcOut` takes the shadow flop contents.
- R7: When `testMode` is 1 and either `scanEn` or `captureStrobe` is 1 at a rising edge, `funcOut` does not change.
- R8: When `scanEn` and `captureStrobe` are both 1, the shift of R4 takes place and no capture happens.
- R9: The logic under test gives response bit i = `funcIn[i]` XOR (`funcIn[(i+1) mod N]` AND `funcIn[(i+2) mod N]`).
- R10: A full pattern is loaded into all chains, and the previous capture is unloaded, in exactly as many shifts as the longest chain has cells.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for every flop |
| rst | input | 1 | Synchronous reset, active high |
| testMode | input | 1 | 1 selects test behaviour of the output flops |
| scanEn | input | 1 | 1 shifts all chains one position |
| captureStrobe | input | 1 | 1 samples the logic response into the shadow flops |
| funcIn | input | NUM_FLOPS | Functional input to the logic under test |
| scanIn | input | NUM_CHAINS | Serial input, one bit per chain |
| scanOut | output | NUM_CHAINS | Serial output, one bit per chain |
| funcOut | output | NUM_FLOPS | Functional output from the output flops |

## Verification
Every input vector of the default 10-cell configuration is passed through the logic in operate mode. Meanwhile `scanEn` and `captureStrobe` toggle, which shows whether the scan path leaks into functional results. Each vector is then captured, unloaded through the three unequal chains while a different vector is loaded, and applied. A wrong capture, a wrong chain order or a wrong chain length gives a mismatched unload. A faulty hold of the output during shift and capture, or a faulty apply, shows up on `funcOut`. A single marker bit shifted out of a cleared bank measures each chain length on its own.

// File: rtl/scan_pkg.sv
package scan_pkg;

  // Strobes sent from the mode decoder to the cells.
  typedef struct packed {
    logic shiftEn;
    logic captureEn;
    logic applyEn;
    logic operateEn;
  } scanStrobe_t;

  // Number of cells in chain k. The first (n mod c) chains are one longer.
  function automatic int chainLen(input int k, input int n, input int c);
    return (n / c) + ((k < (n % c)) ? 1 : 0);
  endfunction

  // Lowest cell index of chain k. Chains are contiguous in ascending order.
  function automatic int chainStart(input int k, input int n, input int c);
    return k * (n / c) + ((k < (n % c)) ? k : (n % c));
  endfunction

  function automatic int maxChainLen(input int n, input int c);
    return (n / c) + (((n % c) != 0) ? 1 : 0);
  endfunction

endpackage

// File: rtl/scan_ctrl.sv
module scan_ctrl
  import scan_pkg::*;
(
  input  logic        testMode,
  input  logic        scanEn,
  input  logic        captureStrobe,
  output scanStrobe_t strobe
);

  // Shift has priority over capture. The output flops follow the logic
  // when not in test mode. In test mode they load the shadow flops only
  // when neither shift nor capture is requested.
  always_comb begin
    strobe.shiftEn   = scanEn;
    strobe.captureEn = !scanEn && captureStrobe;
    strobe.operateEn = !testMode;
    strobe.applyEn   = testMode && !scanEn && !captureStrobe;
  end

endmodule

// File: rtl/scan_cell.sv
module scan_cell
  import scan_pkg::*;
(
  input  logic        clk,
  input  logic        rst,
  input  scanStrobe_t strobe,
  input  logic        dataIn,
  input  logic        serialIn,
  output logic        outQ,
  output logic        shadowQ
);

  always_ff @(posedge clk) begin
    if (rst) begin
      shadowQ <= 1'b0;
      outQ    <= 1'b0;
    end else begin
      if (strobe.shiftEn)
        shadowQ <= serialIn;
      else if (strobe.captureEn)
        shadowQ <= dataIn;

      if (strobe.operateEn)
        outQ <= dataIn;
      else if (strobe.applyEn)
        outQ <= shadowQ;
    end
  end

endmodule

// File: rtl/scan_datapath.sv
module scan_datapath
  import scan_pkg::*;
#(
  parameter int NUM_FLOPS  = 10,
  parameter int NUM_CHAINS = 3
) (
  input  logic                  clk,
  input  logic                  rst,
  input  scanStrobe_t           strobe,
  input  logic [NUM_FLOPS-1:0]  funcIn,
  input  logic [NUM_CHAINS-1:0] scanIn,
  output logic [NUM_CHAINS-1:0] scanOut,
  output logic [NUM_FLOPS-1:0]  funcOut,
  output logic [NUM_FLOPS-1:0]  shadowState
);

  localparam int MAX_LEN = maxChainLen(NUM_FLOPS, NUM_CHAINS);

  logic [NUM_FLOPS-1:0] logicResp;
  logic [NUM_FLOPS-1:0] serialFeed;

  // Logic under test.
  for (genvar i = 0; i < NUM_FLOPS; i++) begin : g_lut
    assign logicResp[i] = funcIn[i] ^
        (funcIn[(i + 1) % NUM_FLOPS] & funcIn[(i + 2) % NUM_FLOPS]);
  end

  // Chain wiring: the first cell of each chain takes its serial input,
  // and every later cell takes the shadow flop of the cell below it.
  for (genvar k = 0; k < NUM_CHAINS; k++) begin : g_chain
    localparam int START = chainStart(k, NUM_FLOPS, NUM_CHAINS);
    localparam int LEN   = chainLen(k, NUM_FLOPS, NUM_CHAINS);
    for (genvar j = 0; j < MAX_LEN; j++) begin : g_pos
      if (j < LEN) begin : g_used
        if (j == 0) begin : g_head
          assign serialFeed[START] = scanIn[k];
        end else begin : g_body
          assign serialFeed[START + j] = shadowState[START + j - 1];
        end
      end
    end
    assign scanOut[k] = shadowState[START + LEN - 1];
  end

  for (genvar i = 0; i < NUM_FLOPS; i++) begin : g_cell
    scan_cell u_cell (
      .clk      (clk),
      .rst      (rst),
      .strobe   (strobe),
      .dataIn   (logicResp[i]),
      .serialIn (serialFeed[i]),
      .outQ     (funcOut[i]),
      .shadowQ  (shadowState[i])
    );
  end

endmodule

// File: rtl/scan_wrap.sv
module scan_wrap
  import scan_pkg::*;
#(
  parameter int NUM_FLOPS  = 10,
  parameter int NUM_CHAINS = 3
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  testMode,
  input  logic                  scanEn,
  input  logic                  captureStrobe,
  input  logic [NUM_FLOPS-1:0]  funcIn,
  input  logic [NUM_CHAINS-1:0] scanIn,
  output logic [NUM_CHAINS-1:0] scanOut,
  output logic [NUM_FLOPS-1:0]  funcOut
);

  scanStrobe_t          strobe;
  logic [NUM_FLOPS-1:0] shadowState;

  scan_ctrl u_ctrl (
    .testMode      (testMode),
    .scanEn        (scanEn),
    .captureStrobe (captureStrobe),
    .strobe        (strobe)
  );

  scan_datapath #(
    .NUM_FLOPS  (NUM_FLOPS),
    .NUM_CHAINS (NUM_CHAINS)
  ) u_dp (
    .clk         (clk),
    .rst         (rst),
    .strobe      (strobe),
    .funcIn      (funcIn),
    .scanIn      (scanIn),
    .scanOut     (scanOut),
    .funcOut     (funcOut),
    .shadowState (shadowState)
  );

endmodule

// File: rtl/scan_wrap_chk.sv
module scan_wrap_chk
  import scan_pkg::*;
#(
  parameter int NUM_FLOPS  = 10,
  parameter int NUM_CHAINS = 3
) (
  input logic                  clk,
  input logic                  rst,
  input logic                  testMode,
  input logic                  scanEn,
  input logic                  captureStrobe,
  input logic [NUM_FLOPS-1:0]  funcIn,
  input logic [NUM_CHAINS-1:0] scanIn,
  input logic [NUM_CHAINS-1:0] scanOut,
  input logic [NUM_FLOPS-1:0]  funcOut,
  input logic [NUM_FLOPS-1:0]  shadowState
);

  logic [NUM_FLOPS-1:0] expResp;
  logic                 rstSeen = 1'b0;

  always_comb begin
    for (int i = 0; i < NUM_FLOPS; i++)
      expResp[i] = funcIn[i] ^ (funcIn[(i + 1) % NUM_FLOPS] & funcIn[(i + 2) % NUM_FLOPS]);
  end

  always_ff @(posedge clk) rstSeen <= rst;

  // R1
  always @(negedge clk) begin
    if (rstSeen) begin
      reset_clear_chk: assert (funcOut == '0 && scanOut == '0 && shadowState == '0);
    end
  end

  // R2
  operate_follow_chk: assert property (@(posedge clk) disable iff (rst)
    !testMode |=> funcOut == $past(expResp));

  // R3
  capture_load_chk: assert property (@(posedge clk) disable iff (rst)
    (!scanEn && captureStrobe) |=> shadowState == $past(expResp));

  // R6
  apply_drive_chk: assert property (@(posedge clk) disable iff (rst)
    (testMode && !scanEn && !captureStrobe) |=> funcOut == $past(shadowState));

  // R7
  test_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (testMode && (scanEn || captureStrobe)) |=> $stable(funcOut));

  for (genvar k = 0; k < NUM_CHAINS; k++) begin : g_chk
    localparam int START = chainStart(k, NUM_FLOPS, NUM_CHAINS);
    localparam int LEN   = chainLen(k, NUM_FLOPS, NUM_CHAINS);
    // R4 R8
    shift_head_chk: assert property (@(posedge clk) disable iff (rst)
      scanEn |=> shadowState[START] == $past(scanIn[k]));
    // R4
    shift_tail_chk: assert property (@(posedge clk) disable iff (rst)
      scanOut[k] == shadowState[START + LEN - 1]);
    for (genvar j = 1; j < LEN; j++) begin : g_body
      // R4
      shift_move_chk: assert property (@(posedge clk) disable iff (rst)
        scanEn |=> shadowState[START + j] == $past(shadowState[START + j - 1]));
    end
  end

endmodule

bind scan_wrap scan_wrap_chk #(
  .NUM_FLOPS  (NUM_FLOPS),
  .NUM_CHAINS (NUM_CHAINS)
) u_chk (
  .clk           (clk),
  .rst           (rst),
  .testMode      (testMode),
  .scanEn        (scanEn),
  .captureStrobe (captureStrobe),
  .funcIn        (funcIn),
  .scanIn        (scanIn),
  .scanOut       (scanOut),
  .funcOut       (funcOut),
  .shadowState   (shadowState)
);

// File: tb/scan_wrap_tb.sv
module scan_wrap_tb;

  localparam int N = 10;
  localparam int C = 3;
  localparam int MAXL = (N / C) + (((N % C) != 0) ? 1 : 0);

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic         testMode = 1'b1;
  logic         scanEn = 1'b0;
  logic         captureStrobe = 1'b0;
  logic [N-1:0] funcIn = '0;
  logic [C-1:0] scanIn = '0;
  logic [C-1:0] scanOut;
  logic [N-1:0] funcOut;

  int  checks = 0;
  int  fails  = 0;
  bit  done   = 1'b0;

  always #5 clk = ~clk;

  scan_wrap #(.NUM_FLOPS(N), .NUM_CHAINS(C)) u_dut (
    .clk           (clk),
    .rst           (rst),
    .testMode      (testMode),
    .scanEn        (scanEn),
    .captureStrobe (captureStrobe),
    .funcIn        (funcIn),
    .scanIn        (scanIn),
    .scanOut       (scanOut),
    .funcOut       (funcOut)
  );

  function automatic int lenOf(input int k);
    return (N / C) + ((k < (N % C)) ? 1 : 0);
  endfunction

  function automatic int startOf(input int k);
    int s = 0;
    for (int m = 0; m < k; m++) s += lenOf(m);
    return s;
  endfunction

  // R9 response, computed bit by bit from the requirement
  function automatic logic [N-1:0] respOf(input logic [N-1:0] x);
    logic [N-1:0] r;
    for (int i = 0; i < N; i++)
      r[i] = x[i] ^ (x[(i + 1) % N] & x[(i + 2) % N]);
    return r;
  endfunction

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic tick();
    @(negedge clk);
  endtask

  initial begin
    logic [N-1:0] expQ;
    logic [N-1:0] gotVec;
    logic [N-1:0] loadVec;

    // R1: reset clears everything even while shifting ones in
    @(negedge clk);
    scanEn = 1'b1;
    scanIn = '1;
    captureStrobe = 1'b1;
    funcIn = '1;
    repeat (3) tick();
    check(funcOut == '0, "R1 funcOut", int'(funcOut), 0);
    check(scanOut == '0, "R1 scanOut", int'(scanOut), 0);

    // R5 R4: a single marker per chain reaches scanOut after len(k) shifts
    rst = 1'b0;
    testMode = 1'b1;
    captureStrobe = 1'b0;
    scanEn = 1'b1;
    scanIn = '1;
    for (int e = 1; e <= MAXL + 1; e++) begin
      tick();
      scanIn = '0;
      for (int k = 0; k < C; k++)
        check(scanOut[k] == (e == lenOf(k)), $sformatf("R5 chain %0d edge %0d", k, e),
              int'(scanOut[k]), int'(e == lenOf(k)));
      check(funcOut == '0, "R7 hold during shift", int'(funcOut), 0);
    end

    // R2 R9: operate sweep with scan controls toggling
    testMode = 1'b0;
    for (int x = 0; x < (1 << N); x++) begin
      funcIn = N'(x);
      scanEn = x[0];
      captureStrobe = x[1];
      scanIn = C'(x);
      tick();
      check(funcOut == respOf(N'(x)), "R2 R9 operate", int'(funcOut), int'(respOf(N'(x))));
    end
    expQ = respOf(N'((1 << N) - 1));

    // R3 R4 R6 R7 R8 R10: capture, unload while loading, apply
    testMode = 1'b1;
    for (int x = 0; x < (1 << N); x++) begin
      loadVec = N'(x * 7 + 3);
      funcIn = N'(x);
      scanEn = 1'b0;
      captureStrobe = 1'b1;
      tick();
      check(funcOut == expQ, "R7 hold during capture", int'(funcOut), int'(expQ));
      gotVec = '0;
      for (int s = 0; s < MAXL; s++) begin
        for (int k = 0; k < C; k++) begin
          if (s < lenOf(k)) gotVec[startOf(k) + lenOf(k) - 1 - s] = scanOut[k];
          scanIn[k] = (MAXL - 1 - s < lenOf(k)) ? loadVec[startOf(k) + MAXL - 1 - s] : 1'b0;
        end
        scanEn = 1'b1;
        captureStrobe = 1'b1;  // R8: shift must win
        funcIn = ~funcIn;
        tick();
        check(funcOut == expQ, "R7 R8 hold during shift", int'(funcOut), int'(expQ));
      end
      check(gotVec == respOf(N'(x)), "R3 R4 R10 unload", int'(gotVec), int'(respOf(N'(x))));
      scanEn = 1'b0;
      captureStrobe = 1'b0;
      tick();
      check(funcOut == loadVec, "R6 R10 apply", int'(funcOut), int'(loadVec));
      expQ = loadVec;
    end

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog expired");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

endmodule